// File: doc/BRIEF.md
# Fixed-Point Speed Tracking Loop

This block estimates shaft speed from a wrapped mechanical angle with a second-order tracking loop in integer arithmetic. On every update strobe it forms the angle error between the input angle and its own angle estimate, feeds the error through a proportional path and an integrating path, and then moves the estimate forward by the new speed times the programmed step time. The step time has to match the period of the update strobe. For example, a 100 µs strobe needs a step time of 100 µs.

The loop takes its input angle from a selector. After reset the selector passes the encoder angle. A software write can switch it to a debug angle that is held inside the block, so the loop can be exercised without a working encoder link. The block drives three outputs from the same speed estimate: the mechanical speed, the electrical speed (mechanical speed times the pole-pair count) and the speed in revolutions per minute.

Angles are unsigned codes of `ANG_W` bits, where a code of 2^ANG_W equals one full turn (2π). Speeds are signed `SPD_W`-bit values in angle codes per second.

Top module: `spd_pll`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first update, all three speed outputs read 0. The internal angle estimate and the integrator also start at 0.
- R2: Loop state and outputs change only on a clock edge where `update_i` is high. Between strobes the outputs hold their values, whatever the angle or gain inputs do.
- R3: The angle error is the selected angle minus the estimate, taken modulo 2^ANG_W and read as a signed value. This places the error in [-π, +π). Example: an input of 0xC000 against an estimate of 0 gives a negative error of -0x4000 and a negative speed.
- R4: On each update the integrator becomes sat(integ + ((err·ki_i·dt_i) >>> (KI_FRAC+DT_FRAC))). The shift is arithmetic, and sat() clamps to the signed `SPD_W` range.
- R5: On each update the mechanical speed output becomes sat(integ_new + ((err·kp_i) >>> KP_FRAC)).
- R6: On each update the estimate becomes (estimate + ((speed_new·dt_i) >>> DT_FRAC)) mod 2^ANG_W.
- R7: The electrical speed output is sat(speed_new·pole_pairs_i). It updates on the same edge as the mechanical speed.
- R8: The rpm output is sat((speed_new·60) >>> (ANG_W−RPM_FRAC)), so it carries RPM_FRAC fraction bits. It updates on the same edge as the mechanical speed.
- R9: A cycle with `dbg_wr_i` high loads both the source bit and the debug angle. `dbg_mode_i`=1 selects the stored debug angle and 0 selects `enc_ang_i`. Every `ANG_W`-bit debug code is a valid angle in [0, 2π).
- R10: After reset the source bit selects the encoder angle. `dbg_mode_i` and `dbg_ang_i` have no effect until `dbg_wr_i` is high.
- R11: The integrator, the mechanical speed and the electrical speed clamp at the signed `SPD_W` limits (+2^31−1 and −2^31 by default) and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | One-cycle strobe that advances the loop by one step |
| enc_ang_i | input | ANG_W | Encoder angle, one turn = 2^ANG_W |
| dbg_wr_i | input | 1 | Load strobe for the source bit and the debug angle |
| dbg_mode_i | input | 1 | Source bit to load: 1 selects the debug angle |
| dbg_ang_i | input | ANG_W | Debug angle to load |
| kp_i | input | GAIN_W | Proportional gain, KP_FRAC fraction bits |
| ki_i | input | GAIN_W | Integral gain, KI_FRAC fraction bits |
| dt_i | input | DT_W | Step time in seconds, DT_FRAC fraction bits |
| pole_pairs_i | input | PP_W | Pole-pair count |
| spd_mech_o | output | SPD_W | Mechanical speed, signed, codes per second |
| spd_el_o | output | SPD_W | Electrical speed, signed |
| spd_rpm_o | output | SPD_W | Speed in rpm, signed, RPM_FRAC fraction bits |

## Verification
The bench targets the following corner cases:
- **Error wrap.** An input angle more than half a turn ahead of the estimate must produce a negative speed. A design that skips the signed wrap would spin the estimate the wrong way.
- **Clamping.** Gains and step time at full scale must drive the outputs to exactly the signed limits. A design with wrapping arithmetic would instead flip sign at full speed.
- **Source selection.** The debug fields are driven before any write strobe, to catch a design that selects the debug angle combinationally or that comes out of reset in debug mode.
- **Strobe gating.** Random gaps between strobes, with the inputs changing during the gaps, catch a loop that integrates on every clock instead of once per strobe.

// File: rtl/spd_pll_pkg.sv
package spd_pll_pkg;
  typedef enum logic {
    SRC_ENC = 1'b0,
    SRC_DBG = 1'b1
  } ang_src_e;
endpackage

// File: rtl/spd_pll_sat.sv
module spd_pll_sat #(
  parameter int IN_W  = 40,
  parameter int OUT_W = 32
) (
  input  logic signed [IN_W-1:0]  in_i,
  output logic signed [OUT_W-1:0] out_o
);
  generate
    if (IN_W > OUT_W) begin : g_clamp
      localparam logic signed [IN_W-1:0] MAXV = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
      localparam logic signed [IN_W-1:0] MINV = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
      always_comb begin
        if (in_i > MAXV)      out_o = MAXV[OUT_W-1:0];
        else if (in_i < MINV) out_o = MINV[OUT_W-1:0];
        else                  out_o = in_i[OUT_W-1:0];
      end
    end else begin : g_pass
      assign out_o = OUT_W'(in_i);
    end
  endgenerate
endmodule

// File: rtl/spd_pll_sel.sv
module spd_pll_sel
  import spd_pll_pkg::*;
#(
  parameter int ANG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbg_wr_i,
  input  logic             dbg_mode_i,
  input  logic [ANG_W-1:0] dbg_ang_i,
  input  logic [ANG_W-1:0] enc_ang_i,
  output logic [ANG_W-1:0] ang_o
);
  ang_src_e         src_q;
  logic [ANG_W-1:0] dbg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_ENC;
      dbg_q <= '0;
    end else if (dbg_wr_i) begin
      src_q <= dbg_mode_i ? SRC_DBG : SRC_ENC;
      dbg_q <= dbg_ang_i;
    end
  end

  assign ang_o = (src_q == SRC_DBG) ? dbg_q : enc_ang_i;

  AST_SRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbg_wr_i |=> $stable(src_q) && $stable(dbg_q)); // R10
  AST_SRC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wr_i |=> (src_q == SRC_DBG) == $past(dbg_mode_i)); // R9
endmodule

// File: rtl/spd_pll_core.sv
module spd_pll_core #(
  parameter int ANG_W   = 16,
  parameter int GAIN_W  = 20,
  parameter int DT_W    = 20,
  parameter int SPD_W   = 32,
  parameter int KP_FRAC = 4,
  parameter int KI_FRAC = 0,
  parameter int DT_FRAC = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    update_i,
  input  logic [ANG_W-1:0]        ang_i,
  input  logic [GAIN_W-1:0]       kp_i,
  input  logic [GAIN_W-1:0]       ki_i,
  input  logic [DT_W-1:0]         dt_i,
  output logic signed [SPD_W-1:0] spd_nxt_o,
  output logic signed [SPD_W-1:0] spd_q_o
);
  localparam int PW_I = ANG_W + GAIN_W + DT_W + 2;
  localparam int PW_A = SPD_W + DT_W + 2;
  localparam int PW   = (PW_I > PW_A) ? PW_I : PW_A;
  localparam int I_SH = KI_FRAC + DT_FRAC;
  localparam logic signed [SPD_W-1:0] SPD_MAX = {1'b0, {(SPD_W-1){1'b1}}};

  logic [ANG_W-1:0]        est_q, est_nxt;
  logic signed [SPD_W-1:0] integ_q, integ_nxt, spd_q;
  logic signed [ANG_W-1:0] err;
  logic signed [PW-1:0]    err_x, kp_x, ki_x, dt_x;
  logic signed [PW-1:0]    integ_sum, spd_sum, dang;

  // modular subtraction: signed view of the difference is the wrapped error
  assign err   = ang_i - est_q;
  assign err_x = PW'(err);
  assign kp_x  = $signed(PW'({1'b0, kp_i}));
  assign ki_x  = $signed(PW'({1'b0, ki_i}));
  assign dt_x  = $signed(PW'({1'b0, dt_i}));

  assign integ_sum = PW'(integ_q) + ((err_x * ki_x * dt_x) >>> I_SH);

  spd_pll_sat #(.IN_W(PW), .OUT_W(SPD_W)) u_sat_integ (
    .in_i (integ_sum),
    .out_o(integ_nxt)
  );

  assign spd_sum = PW'(integ_nxt) + ((err_x * kp_x) >>> KP_FRAC);

  spd_pll_sat #(.IN_W(PW), .OUT_W(SPD_W)) u_sat_spd (
    .in_i (spd_sum),
    .out_o(spd_nxt_o)
  );

  assign dang    = (PW'(spd_nxt_o) * dt_x) >>> DT_FRAC;
  assign est_nxt = ANG_W'(PW'(est_q) + dang);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
      spd_q   <= '0;
      est_q   <= '0;
    end else if (update_i) begin
      integ_q <= integ_nxt;
      spd_q   <= spd_nxt_o;
      est_q   <= est_nxt;
    end
  end

  assign spd_q_o = spd_q;

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(integ_q) && $stable(est_q) && $stable(spd_q)); // R2
  AST_INTEG_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && (integ_q == SPD_MAX) && !err[ANG_W-1] |=> integ_q == SPD_MAX); // R11
  AST_ZERO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && (ang_i == est_q) |=> integ_q == $past(integ_q)); // R4
endmodule

// File: rtl/spd_pll_scale.sv
module spd_pll_scale #(
  parameter int ANG_W    = 16,
  parameter int SPD_W    = 32,
  parameter int PP_W     = 8,
  parameter int RPM_FRAC = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    update_i,
  input  logic signed [SPD_W-1:0] spd_nxt_i,
  input  logic signed [SPD_W-1:0] spd_mech_i,
  input  logic [PP_W-1:0]         pole_pairs_i,
  output logic signed [SPD_W-1:0] spd_el_o,
  output logic signed [SPD_W-1:0] spd_rpm_o
);
  localparam int EW     = SPD_W + PP_W + 1;
  localparam int RW     = SPD_W + 8;
  localparam int RPM_SH = ANG_W - RPM_FRAC;

  logic signed [EW-1:0]    el_p;
  logic signed [RW-1:0]    rpm_p;
  logic signed [SPD_W-1:0] el_s, rpm_s, el_q, rpm_q;

  assign el_p  = EW'(spd_nxt_i) * $signed(EW'({1'b0, pole_pairs_i}));
  assign rpm_p = (RW'(spd_nxt_i) * $signed(RW'(60))) >>> RPM_SH;

  spd_pll_sat #(.IN_W(EW), .OUT_W(SPD_W)) u_sat_el (
    .in_i (el_p),
    .out_o(el_s)
  );

  spd_pll_sat #(.IN_W(RW), .OUT_W(SPD_W)) u_sat_rpm (
    .in_i (rpm_p),
    .out_o(rpm_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      el_q  <= '0;
      rpm_q <= '0;
    end else if (update_i) begin
      el_q  <= el_s;
      rpm_q <= rpm_s;
    end
  end

  assign spd_el_o  = el_q;
  assign spd_rpm_o = rpm_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> $stable(el_q) && $stable(rpm_q)); // R2
  AST_EL_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i && (pole_pairs_i != '0) |=> (el_q == '0) == (spd_mech_i == '0)); // R7
  AST_RPM_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (rpm_q[SPD_W-1] == 1'b0) || spd_mech_i[SPD_W-1]); // R8
endmodule

// File: rtl/spd_pll.sv
module spd_pll #(
  parameter int ANG_W    = 16,
  parameter int GAIN_W   = 20,
  parameter int DT_W     = 20,
  parameter int SPD_W    = 32,
  parameter int PP_W     = 8,
  parameter int KP_FRAC  = 4,
  parameter int KI_FRAC  = 0,
  parameter int DT_FRAC  = 24,
  parameter int RPM_FRAC = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    update_i,
  input  logic [ANG_W-1:0]        enc_ang_i,
  input  logic                    dbg_wr_i,
  input  logic                    dbg_mode_i,
  input  logic [ANG_W-1:0]        dbg_ang_i,
  input  logic [GAIN_W-1:0]       kp_i,
  input  logic [GAIN_W-1:0]       ki_i,
  input  logic [DT_W-1:0]         dt_i,
  input  logic [PP_W-1:0]         pole_pairs_i,
  output logic signed [SPD_W-1:0] spd_mech_o,
  output logic signed [SPD_W-1:0] spd_el_o,
  output logic signed [SPD_W-1:0] spd_rpm_o
);
  logic [ANG_W-1:0]        ang_sel;
  logic signed [SPD_W-1:0] spd_nxt, spd_q;

  spd_pll_sel #(.ANG_W(ANG_W)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dbg_wr_i  (dbg_wr_i),
    .dbg_mode_i(dbg_mode_i),
    .dbg_ang_i (dbg_ang_i),
    .enc_ang_i (enc_ang_i),
    .ang_o     (ang_sel)
  );

  spd_pll_core #(
    .ANG_W(ANG_W), .GAIN_W(GAIN_W), .DT_W(DT_W), .SPD_W(SPD_W),
    .KP_FRAC(KP_FRAC), .KI_FRAC(KI_FRAC), .DT_FRAC(DT_FRAC)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .update_i (update_i),
    .ang_i    (ang_sel),
    .kp_i     (kp_i),
    .ki_i     (ki_i),
    .dt_i     (dt_i),
    .spd_nxt_o(spd_nxt),
    .spd_q_o  (spd_q)
  );

  spd_pll_scale #(
    .ANG_W(ANG_W), .SPD_W(SPD_W), .PP_W(PP_W), .RPM_FRAC(RPM_FRAC)
  ) u_scale (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .update_i    (update_i),
    .spd_nxt_i   (spd_nxt),
    .spd_mech_i  (spd_q),
    .pole_pairs_i(pole_pairs_i),
    .spd_el_o    (spd_el_o),
    .spd_rpm_o   (spd_rpm_o)
  );

  assign spd_mech_o = spd_q;

  AST_RESET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> spd_mech_o == '0 && spd_el_o == '0 && spd_rpm_o == '0); // R1
endmodule

// File: tb/spd_pll_bench.sv
module spd_pll_bench;
  localparam longint SMAX = 64'sd2147483647;
  localparam longint SMIN = -64'sd2147483648;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        update_i = 1'b0;
  logic [15:0] enc_ang_i = '0;
  logic        dbg_wr_i = 1'b0;
  logic        dbg_mode_i = 1'b0;
  logic [15:0] dbg_ang_i = '0;
  logic [19:0] kp_i = '0, ki_i = '0, dt_i = '0;
  logic [7:0]  pole_pairs_i = '0;
  logic signed [31:0] spd_mech_o, spd_el_o, spd_rpm_o;

  int errors = 0;
  int checks = 0;

  longint      m_integ, m_spd, m_el, m_rpm;
  logic [15:0] m_est, m_dbg;
  bit          m_mode;

  always #4 clk = ~clk;

  spd_pll u_spd_pll (
    .clk_i(clk), .rst_ni(rst_ni), .update_i(update_i), .enc_ang_i(enc_ang_i),
    .dbg_wr_i(dbg_wr_i), .dbg_mode_i(dbg_mode_i), .dbg_ang_i(dbg_ang_i),
    .kp_i(kp_i), .ki_i(ki_i), .dt_i(dt_i), .pole_pairs_i(pole_pairs_i),
    .spd_mech_o(spd_mech_o), .spd_el_o(spd_el_o), .spd_rpm_o(spd_rpm_o)
  );

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  function automatic void model_step();
    logic [15:0]        a;
    logic signed [15:0] e;
    longint             ev, dang;
    a  = m_mode ? m_dbg : enc_ang_i;
    e  = a - m_est;
    ev = longint'(e);
    m_integ = sat(m_integ + ((ev * longint'(ki_i) * longint'(dt_i)) >>> 24));
    m_spd   = sat(m_integ + ((ev * longint'(kp_i)) >>> 4));
    dang    = (m_spd * longint'(dt_i)) >>> 24;
    m_est   = m_est + dang[15:0];
    m_el    = sat(m_spd * longint'(pole_pairs_i));
    m_rpm   = sat((m_spd * 60) >>> 8);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    chk({tag, " mech R4/R5/R6"}, longint'(spd_mech_o), m_spd);
    chk({tag, " el R7"}, longint'(spd_el_o), m_el);
    chk({tag, " rpm R8"}, longint'(spd_rpm_o), m_rpm);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    update_i = 1'b0;
    dbg_wr_i = 1'b0;
    m_integ = 0; m_spd = 0; m_el = 0; m_rpm = 0;
    m_est = '0; m_dbg = '0; m_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 in reset", longint'(spd_mech_o) | longint'(spd_el_o) | longint'(spd_rpm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_update(input string tag);
    update_i = 1'b1;
    model_step();
    @(negedge clk);
    update_i = 1'b0;
    check_outs(tag);
  endtask

  task automatic dbg_write(input bit mode, input logic [15:0] ang);
    dbg_wr_i = 1'b1;
    dbg_mode_i = mode;
    dbg_ang_i = ang;
    @(negedge clk);
    dbg_wr_i = 1'b0;
    m_mode = mode;
    m_dbg = ang;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint hold_m, hold_e, hold_r;
    void'($urandom(32'd1234));
    do_reset();
    chk("R1 after reset", longint'(spd_mech_o) | longint'(spd_el_o) | longint'(spd_rpm_o), 0);

    // R10: debug fields driven but never written
    kp_i = 20'd4000; ki_i = 20'd20000; dt_i = 20'd1678; pole_pairs_i = 8'd3;
    enc_ang_i = 16'h2000; dbg_mode_i = 1'b1; dbg_ang_i = 16'h9000;
    pulse_update("R10 encoder source");
    chk("R10 sign positive", longint'(spd_mech_o > 0), 1);

    // R3: wrap of error, debug source
    do_reset();
    dbg_write(1'b1, 16'hC000);
    enc_ang_i = 16'h1000;
    pulse_update("R3 R9 debug wrap");
    chk("R3 negative speed", longint'(spd_mech_o < 0), 1);
    dbg_write(1'b0, 16'h0000);
    pulse_update("R9 back to encoder");

    // R11: full-scale gains clamp outputs
    do_reset();
    kp_i = '1; ki_i = '1; dt_i = '1; pole_pairs_i = 8'd255;
    enc_ang_i = 16'h7FFF;
    pulse_update("R11 pos");
    chk("R11 mech max", longint'(spd_mech_o), SMAX);
    chk("R11 el max", longint'(spd_el_o), SMAX);
    do_reset();
    enc_ang_i = 16'h8000;
    pulse_update("R11 neg");
    chk("R11 mech min", longint'(spd_mech_o), SMIN);
    chk("R11 el min", longint'(spd_el_o), SMIN);
    pulse_update("R11 follow");

    // random phase
    do_reset();
    for (int i = 0; i < 400; i++) begin
      kp_i = 20'($urandom);
      ki_i = ($urandom_range(0, 1) == 1) ? 20'($urandom) : 20'($urandom_range(0, 50000));
      dt_i = ($urandom_range(0, 1) == 1) ? 20'($urandom) : 20'($urandom_range(0, 4000));
      pole_pairs_i = 8'($urandom);
      enc_ang_i = 16'($urandom);
      if ($urandom_range(0, 9) == 0) dbg_write(1'($urandom), 16'($urandom));
      pulse_update("rand");
      hold_m = longint'(spd_mech_o);
      hold_e = longint'(spd_el_o);
      hold_r = longint'(spd_rpm_o);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        enc_ang_i = 16'($urandom);
        kp_i = 20'($urandom);
        @(negedge clk);
      end
      if (i % 20 == 0) begin
        chk("R2 hold mech", longint'(spd_mech_o), hold_m);
        chk("R2 hold el", longint'(spd_el_o), hold_e);
        chk("R2 hold rpm", longint'(spd_rpm_o), hold_r);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule